// File: doc/BRIEF.md
# DRAM Channel Power-State Manager

This block sits next to the command scheduler of one DDR3 channel and decides when the channel drops into a low-power mode. It watches four things: whether requests are pending, whether reads are still outstanding, whether all banks are precharged, and whether software has asked for self-refresh. When the channel has been idle for a programmable number of cycles, it enters precharge power-down. When self-refresh is requested and the channel is idle, it takes a two-cycle fast path into self-refresh. While in self-refresh it gates the internal command clock. On every exit it holds the scheduler off for a programmable delay.

Separately from the state machine, it does three more things. It tristates the address, command and bank pins whenever no chip-select is asserted. It puts the read receivers in standby whenever no read is in flight. It can throttle command activity by blocking a programmable share of the cycles in a repeating window.

Top module: `dram_pwr_mgr`

## Requirements
- R1: After reset, `ready_o` and `clk_en_o` are 1 and `pd_entry_o`, `pd_exit_o`, `sr_entry_o` and `sr_exit_o` are 0.
- R2: The channel is idle when `req_pend_i` is 0, `rd_out_i` is 0 and `banks_idle_i` is 1. If it stays idle with `idle_lim_i` = L >= 1, then `pd_entry_o` pulses for one cycle in the (L+2)-th cycle after idle is first presented. `ready_o` is 0 from the cycle before that pulse until the exit completes.
- R3: With `idle_lim_i` = 0, precharge power-down is never entered: `pd_entry_o` stays 0 and `ready_o` stays 1 however long the channel is idle.
- R4: With `sr_req_i` = 1 and the channel idle, `sr_entry_o` pulses in the second cycle. From that cycle until the exit, `clk_en_o` is 0. `ready_o` is never 1 while `clk_en_o` is 0.
- R5: Exit from power-down happens when `req_pend_i` rises. Exit from self-refresh happens when `req_pend_i` rises or `sr_req_i` falls. The matching exit pulse (`pd_exit_o` or `sr_exit_o`) and the return of `clk_en_o` to 1 appear in the next cycle. `ready_o` returns in the (`exit_dly_i`+2)-th cycle after the trigger.
- R6: If a request arrives during an entry cycle, before the low-power command has issued, entry is aborted. No entry pulse is produced, `clk_en_o` stays 1, and `ready_o` is 1 again in the next cycle.
- R7: `ca_tri_o` is 1 exactly when every bit of the active-low `cs_n_i` is 1. It is never 1 while any chip-select is asserted.
- R8: `rx_stby_o` is 1 exactly when `rd_out_i` is 0 and `rd_issue_i` is 0, so the receivers wake in the same cycle a read command issues.
- R9: With `thr_en_i` = 1, every window of `thr_win_i`+1 cycles contains min(`thr_blk_i`, `thr_win_i`+1) cycles in which `ready_o` is 0. With `thr_en_i` = 0, no cycle is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_pend_i | input | 1 | Request queue not empty |
| rd_out_i | input | RDW | Number of outstanding reads |
| rd_issue_i | input | 1 | A read command issues this cycle |
| banks_idle_i | input | 1 | All banks precharged |
| cs_n_i | input | NCS | Active-low chip-selects from the scheduler |
| sr_req_i | input | 1 | Self-refresh requested |
| idle_lim_i | input | IDLEW | Idle cycles before power-down; 0 disables power-down |
| exit_dly_i | input | EXW | Extra not-ready cycles after a low-power exit |
| thr_en_i | input | 1 | Throttle enable |
| thr_blk_i | input | THRW | Blocked cycles per throttle window |
| thr_win_i | input | THRW | Throttle window length minus one |
| ready_o | output | 1 | Scheduler may issue a command |
| pd_entry_o | output | 1 | Power-down entry command strobe |
| pd_exit_o | output | 1 | Power-down exit command strobe |
| sr_entry_o | output | 1 | Self-refresh entry command strobe |
| sr_exit_o | output | 1 | Self-refresh exit command strobe |
| clk_en_o | output | 1 | Internal command clock enable |
| ca_tri_o | output | 1 | Tristate enable for address, command and bank pins |
| rx_stby_o | output | 1 | Read receiver standby |

## Verification
The following invariants are checked by the assertions on every cycle:
- The state register is one-hot.
- An entry strobe is always a single cycle and lands in the low-power state.
- A zero idle limit never leads into the idle count.
- The scheduler is never ready while the clock is gated.
- The clock is running again when the self-refresh exit strobe fires.

The following behaviours can only be shown by the bench's scenarios:
- The exact cycle counts of the idle threshold and of the exit delay.
- The abort-versus-wait split for requests that arrive during entry.
- The blocked-cycle ratio of the throttle.
- The pin tristate and receiver standby responses to chip-select and read activity.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int NST = 7;
  typedef enum int unsigned {
    S_ACT  = 0,
    S_IDLE = 1,
    S_PDE  = 2,
    S_PD   = 3,
    S_SRE  = 4,
    S_SR   = 5,
    S_EXW  = 6
  } st_idx_e;
endpackage

// File: rtl/dpm_fsm.sv
module dpm_fsm
  import dpm_pkg::*;
#(
  parameter int IDLEW = 8,
  parameter int EXW   = 6,
  parameter int RDW   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_pend_i,
  input  logic [RDW-1:0]   rd_out_i,
  input  logic             banks_idle_i,
  input  logic             sr_req_i,
  input  logic [IDLEW-1:0] idle_lim_i,
  input  logic [EXW-1:0]   exit_dly_i,
  output logic [NST-1:0]   st_o,
  output logic             pd_entry_o,
  output logic             pd_exit_o,
  output logic             sr_entry_o,
  output logic             sr_exit_o,
  output logic             clk_en_o
);
  logic [NST-1:0]   st_q, nxt;
  logic [IDLEW-1:0] icnt_q;
  logic [EXW-1:0]   ecnt_q;
  logic             idle;
  logic             pd_entry_q, pd_exit_q, sr_entry_q, sr_exit_q, clk_en_q;

  assign idle = !req_pend_i && (rd_out_i == '0) && banks_idle_i;

  always_comb begin
    nxt = '0;
    if (st_q[S_ACT]) begin
      if (idle && sr_req_i)                nxt[S_SRE]  = 1'b1;
      else if (idle && idle_lim_i != '0)   nxt[S_IDLE] = 1'b1;
      else                                 nxt[S_ACT]  = 1'b1;
    end else if (st_q[S_IDLE]) begin
      if (!idle || idle_lim_i == '0)       nxt[S_ACT]  = 1'b1;
      else if (sr_req_i)                   nxt[S_SRE]  = 1'b1;
      else if (icnt_q >= idle_lim_i)       nxt[S_PDE]  = 1'b1;
      else                                 nxt[S_IDLE] = 1'b1;
    end else if (st_q[S_PDE]) begin
      if (req_pend_i) nxt[S_ACT] = 1'b1;   // abort: command not yet issued
      else            nxt[S_PD]  = 1'b1;
    end else if (st_q[S_PD]) begin
      if (req_pend_i) nxt[S_EXW] = 1'b1;
      else            nxt[S_PD]  = 1'b1;
    end else if (st_q[S_SRE]) begin
      if (req_pend_i) nxt[S_ACT] = 1'b1;
      else            nxt[S_SR]  = 1'b1;
    end else if (st_q[S_SR]) begin
      if (req_pend_i || !sr_req_i) nxt[S_EXW] = 1'b1;
      else                         nxt[S_SR]  = 1'b1;
    end else if (st_q[S_EXW]) begin
      if (ecnt_q == '0) nxt[S_ACT] = 1'b1;
      else              nxt[S_EXW] = 1'b1;
    end else begin
      nxt[S_ACT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= NST'(1) << S_ACT;
      icnt_q     <= '0;
      ecnt_q     <= '0;
      pd_entry_q <= 1'b0;
      pd_exit_q  <= 1'b0;
      sr_entry_q <= 1'b0;
      sr_exit_q  <= 1'b0;
      clk_en_q   <= 1'b1;
    end else begin
      st_q <= nxt;
      if (st_q[S_IDLE] && nxt[S_IDLE]) begin
        if (icnt_q != '1) icnt_q <= icnt_q + 1'b1;
      end else begin
        icnt_q <= IDLEW'(1);
      end
      if (nxt[S_EXW] && !st_q[S_EXW])        ecnt_q <= exit_dly_i;
      else if (st_q[S_EXW] && ecnt_q != '0)  ecnt_q <= ecnt_q - 1'b1;
      pd_entry_q <= st_q[S_PDE] && nxt[S_PD];
      sr_entry_q <= st_q[S_SRE] && nxt[S_SR];
      pd_exit_q  <= st_q[S_PD]  && nxt[S_EXW];
      sr_exit_q  <= st_q[S_SR]  && nxt[S_EXW];
      clk_en_q   <= !nxt[S_SR];
    end
  end

  assign st_o       = st_q;
  assign pd_entry_o = pd_entry_q;
  assign pd_exit_o  = pd_exit_q;
  assign sr_entry_o = sr_entry_q;
  assign sr_exit_o  = sr_exit_q;
  assign clk_en_o   = clk_en_q;

  AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q) == 1); // R2
  AST_PD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_entry_q |=> !pd_entry_q); // R2
  AST_PD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_entry_q |-> st_q[S_PD]); // R2
  AST_ZERO_LIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_ACT] && idle_lim_i == '0) |=> !st_q[S_IDLE]); // R3
  AST_SR_EXIT_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_q |-> clk_en_q); // R5
endmodule

// File: rtl/dpm_throttle.sv
module dpm_throttle #(
  parameter int THRW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [THRW-1:0] blk_i,
  input  logic [THRW-1:0] win_i,
  output logic            blk_o
);
  logic [THRW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (!en_i)           phase_q <= '0;
    else if (phase_q >= win_i) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign blk_o = en_i && (phase_q < blk_i);
endmodule

// File: rtl/dpm_pin_ctl.sv
module dpm_pin_ctl #(
  parameter int NCS = 2,
  parameter int RDW = 5
) (
  input  logic [NCS-1:0] cs_n_i,
  input  logic [RDW-1:0] rd_out_i,
  input  logic           rd_issue_i,
  output logic           ca_tri_o,
  output logic           rx_stby_o
);
  assign ca_tri_o  = &cs_n_i;
  assign rx_stby_o = (rd_out_i == '0) && !rd_issue_i;
endmodule

// File: rtl/dram_pwr_mgr.sv
module dram_pwr_mgr
  import dpm_pkg::*;
#(
  parameter int NCS   = 2,
  parameter int RDW   = 5,
  parameter int IDLEW = 8,
  parameter int EXW   = 6,
  parameter int THRW  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_pend_i,
  input  logic [RDW-1:0]   rd_out_i,
  input  logic             rd_issue_i,
  input  logic             banks_idle_i,
  input  logic [NCS-1:0]   cs_n_i,
  input  logic             sr_req_i,
  input  logic [IDLEW-1:0] idle_lim_i,
  input  logic [EXW-1:0]   exit_dly_i,
  input  logic             thr_en_i,
  input  logic [THRW-1:0]  thr_blk_i,
  input  logic [THRW-1:0]  thr_win_i,
  output logic             ready_o,
  output logic             pd_entry_o,
  output logic             pd_exit_o,
  output logic             sr_entry_o,
  output logic             sr_exit_o,
  output logic             clk_en_o,
  output logic             ca_tri_o,
  output logic             rx_stby_o
);
  logic [NST-1:0] st;
  logic           blk;

  dpm_fsm #(.IDLEW(IDLEW), .EXW(EXW), .RDW(RDW)) u_fsm (
    .clk_i, .rst_ni, .req_pend_i, .rd_out_i, .banks_idle_i, .sr_req_i,
    .idle_lim_i, .exit_dly_i, .st_o(st), .pd_entry_o, .pd_exit_o,
    .sr_entry_o, .sr_exit_o, .clk_en_o
  );

  dpm_throttle #(.THRW(THRW)) u_thr (
    .clk_i, .rst_ni, .en_i(thr_en_i), .blk_i(thr_blk_i), .win_i(thr_win_i),
    .blk_o(blk)
  );

  dpm_pin_ctl #(.NCS(NCS), .RDW(RDW)) u_pin (
    .cs_n_i, .rd_out_i, .rd_issue_i, .ca_tri_o, .rx_stby_o
  );

  assign ready_o = (st[S_ACT] || st[S_IDLE]) && !blk;

  AST_GATED_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !ready_o); // R4
  AST_SR_ENTRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_entry_o |-> !clk_en_o); // R4
endmodule

// File: tb/sim_dram_pwr_mgr.sv
module sim_dram_pwr_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_pend = 1'b1;
  logic [4:0] rd_out = '0;
  logic       rd_issue = 1'b0;
  logic       banks_idle = 1'b1;
  logic [1:0] cs_n = 2'b11;
  logic       sr_req = 1'b0;
  logic [7:0] idle_lim = 8'd0;
  logic [5:0] exit_dly = 6'd0;
  logic       thr_en = 1'b0;
  logic [3:0] thr_blk = '0, thr_win = '0;
  logic ready, pd_entry, pd_exit, sr_entry, sr_exit, clk_en, ca_tri, rx_stby;

  int nchk = 0, nerr = 0, gate_viol = 0, tri_viol = 0;

  always #10 clk = ~clk;

  dram_pwr_mgr u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_pend_i(req_pend), .rd_out_i(rd_out),
    .rd_issue_i(rd_issue), .banks_idle_i(banks_idle), .cs_n_i(cs_n),
    .sr_req_i(sr_req), .idle_lim_i(idle_lim), .exit_dly_i(exit_dly),
    .thr_en_i(thr_en), .thr_blk_i(thr_blk), .thr_win_i(thr_win),
    .ready_o(ready), .pd_entry_o(pd_entry), .pd_exit_o(pd_exit),
    .sr_entry_o(sr_entry), .sr_exit_o(sr_exit), .clk_en_o(clk_en),
    .ca_tri_o(ca_tri), .rx_stby_o(rx_stby)
  );

  always @(negedge clk) begin
    if (rst_n && !clk_en && ready) gate_viol++;
    if (ca_tri && !(&cs_n)) tri_viol++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_active();
    req_pend = 1'b1; sr_req = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (ready) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (ready) begin n = k; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 ready", ready, 1);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 strobes", pd_entry + pd_exit + sr_entry + sr_exit, 0);
  endtask

  task automatic t_pd(input int lim, input int dly);
    int n = 0, x;
    idle_lim = 8'(lim); exit_dly = 6'(dly);
    @(negedge clk); req_pend = 1'b0; banks_idle = 1'b1; rd_out = '0;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (pd_entry) begin n = k; break; end
    end
    chk("R2 entry cycle", n, lim + 2);
    chk("R2 not ready in pd", ready, 0);
    req_pend = 1'b1;
    @(negedge clk);
    chk("R5 pd_exit pulse", pd_exit, 1);
    x = ready ? 1 : 0;
    if (x == 1) n = 1; else begin wait_ready(n); n = n + 1; end
    chk("R5 pd exit delay", n, dly + 2);
    go_active();
  endtask

  task automatic t_zero_lim();
    int pulses = 0, lows = 0;
    idle_lim = 8'd0;
    @(negedge clk); req_pend = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pd_entry) pulses++;
      if (!ready) lows++;
    end
    chk("R3 no pd entry", pulses, 0);
    chk("R3 stays ready", lows, 0);
    go_active();
  endtask

  task automatic t_pd_abort();
    int seen = 0;
    idle_lim = 8'd3; exit_dly = 6'd2;
    @(negedge clk); req_pend = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 not ready in entry", ready, 0);
    req_pend = 1'b1;
    @(negedge clk);
    chk("R6 pd abort ready", ready, 1);
    for (int k = 0; k < 6; k++) begin
      if (pd_entry) seen++;
      @(negedge clk);
    end
    chk("R6 pd abort no strobe", seen, 0);
    go_active();
  endtask

  task automatic t_sr(input int dly, input bit by_req);
    int n, gated = 1;
    idle_lim = 8'd0; exit_dly = 6'(dly);
    @(negedge clk); req_pend = 1'b0; sr_req = 1'b1;
    @(negedge clk);
    chk("R4 sre clk on", clk_en, 1);
    @(negedge clk);
    chk("R4 sr_entry pulse", sr_entry, 1);
    chk("R4 clk gated", clk_en, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (clk_en || ready) gated = 0;
    end
    chk("R4 held gated", gated, 1);
    if (by_req) req_pend = 1'b1; else sr_req = 1'b0;
    @(negedge clk);
    chk("R5 sr_exit pulse", sr_exit, 1);
    chk("R5 clk back", clk_en, 1);
    if (ready) n = 1; else begin wait_ready(n); n = n + 1; end
    chk("R5 sr exit delay", n, dly + 2);
    go_active();
  endtask

  task automatic t_sr_abort();
    @(negedge clk); req_pend = 1'b0; sr_req = 1'b1;
    @(negedge clk); req_pend = 1'b1;
    @(negedge clk);
    chk("R6 sr abort strobe", sr_entry, 0);
    chk("R6 sr abort clk", clk_en, 1);
    chk("R6 sr abort ready", ready, 1);
    go_active();
  endtask

  task automatic t_pins();
    cs_n = 2'b11; #1 chk("R7 tri all high", ca_tri, 1);
    cs_n = 2'b10; #1 chk("R7 cs0 asserted", ca_tri, 0);
    cs_n = 2'b01; #1 chk("R7 cs1 asserted", ca_tri, 0);
    cs_n = 2'b00; #1 chk("R7 both asserted", ca_tri, 0);
    cs_n = 2'b11;
    rd_out = 0; rd_issue = 0; #1 chk("R8 standby", rx_stby, 1);
    rd_issue = 1; #1 chk("R8 wake on issue", rx_stby, 0);
    rd_issue = 0; rd_out = 5'd3; #1 chk("R8 awake outstanding", rx_stby, 0);
    rd_out = 0; #1;
  endtask

  task automatic t_throttle();
    int lows = 0;
    req_pend = 1'b1;
    @(negedge clk); thr_win = 4'd4; thr_blk = 4'd2; thr_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!ready) lows++;
    end
    chk("R9 ratio 2 of 5", lows, 4);
    thr_win = 4'd3; thr_blk = 4'd7; lows = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!ready) lows++;
    end
    chk("R9 full block", lows, 8);
    thr_en = 1'b0;
    @(negedge clk);
    chk("R9 off unblocked", ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pd(1, 3);
    t_pd(4, 0);
    t_zero_lim();
    t_pd_abort();
    t_sr(2, 1'b0);
    t_sr(5, 1'b1);
    t_sr_abort();
    t_pins();
    t_throttle();
    chk("R4 no ready while gated", gate_viol, 0);
    chk("R7 no tri with cs", tri_viol, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule